// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control section of a 12-bit successive-approximation converter with eight selectable inputs. A falling edge on the active-low read/convert strobe starts a conversion. The block then waits out a settle and acquisition interval. After that it runs one trial per result bit, from the most significant to the least, and drives the trial code to an external DAC. A one-bit comparator input reports whether the sampled input is at or above that code. A status output is high while a conversion runs, and a clock-enable output gates the conversion clock only for that time.

When the conversion has finished and the strobe is high, the result goes out on an 8-bit tri-state bus. A byte-select input chooses which part appears: the upper eight bits, or the lower four bits with zeros above them. The 3-bit channel address is not latched. It passes straight through to the multiplexer select output. The analog multiplexer, sample-and-hold, DAC and comparator lie outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A high-to-low transition of `rc_n` while no conversion is running starts a conversion: `busy` is high one clock later. Whenever `rc_n` is low, `bus_en` is 0 and the bus is high impedance.
- R2: The register is cleared when a conversion starts: `dac_code` is all zeros throughout the acquisition interval.
- R3: A falling edge of `rc_n` while `busy` is high has no effect on the run length or the result. Holding `rc_n` low after a conversion ends does not start another one.
- R4: `busy` stays high for exactly `ACQ_CYC + 12*TRIAL_CYC` clocks. `conv_clk_en` is high in exactly the same cycles as `busy`.
- R5: The bus is driven (`bus_en`=1) only when a finished result exists, `busy` is low and `rc_n` is high.
- R6: The bits are tried from MSB to LSB. A trial bit is kept when `cmp_in`=1 (input at or above `dac_code`) in the last cycle of its trial. With an ideal comparator, the final result equals the input code for every value, including 0x000 and 0xFFF.
- R7: With `byte_sel`=0 the bus carries result bits [11:4]. With `byte_sel`=1 it carries 0000 followed by result bits [3:0].
- R8: `mux_sel` equals `chan_addr` in the same cycle at all times, including during a conversion.
- R9: A synchronous reset (`rst`=1) gives `busy`=0, `conv_clk_en`=0, `bus_en`=0 and `dac_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rc_n | input | 1 | Read/convert strobe: falling edge starts a conversion, high enables reading |
| byte_sel | input | 1 | 0 selects the upper byte, 1 selects the low nibble |
| chan_addr | input | 3 | Channel address |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| mux_sel | output | 3 | Multiplexer select, equal to `chan_addr` |
| dac_code | output | 12 | Current trial code / result register |
| busy | output | 1 | Conversion in progress |
| conv_clk_en | output | 1 | Conversion clock enable |
| bus_en | output | 1 | High when the data bus is driven |
| data_bus | output | 8 | Tri-state result bus |

## Verification
The comparator is modelled as an ideal compare of a chosen input code against `dac_code`. Directed codes are tried first: all zeros, all ones, the two values on either side of mid-scale, and the single-LSB values. These separate a wrong bit order, a bit that is always kept and a bit that is always dropped. Random codes follow, and in some runs extra strobe pulses are injected during the conversion or the strobe is held low past its end. These show whether a start is wrongly accepted, which would change the run length or the code. Each result is read in both byte-select settings to check the split of the result and the zero fill of the nibble.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_W     = 12,
  parameter int BUS_W     = 8,
  parameter int CH_W      = 3,
  parameter int ACQ_CYC   = 380,
  parameter int TRIAL_CYC = 135
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rc_n,
  input  logic             byte_sel,
  input  logic [CH_W-1:0]  chan_addr,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] dac_code,
  output logic             busy,
  output logic             conv_clk_en,
  output logic             bus_en,
  output logic [BUS_W-1:0] data_bus
);
  localparam int LO_W  = RES_W - BUS_W;
  localparam int IW    = $clog2(RES_W);
  localparam int MAXC  = (ACQ_CYC > TRIAL_CYC) ? ACQ_CYC : TRIAL_CYC;
  localparam int CW    = $clog2(MAXC) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_TRIAL} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [RES_W-1:0] sar;
  logic             busy_q, valid, rc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sar    <= '0;
      busy_q <= 1'b0;
      valid  <= 1'b0;
      rc_q   <= 1'b1;
    end else begin
      rc_q <= rc_n;
      case (st)
        S_IDLE: if (!rc_n && rc_q) begin
          st     <= S_ACQ;
          busy_q <= 1'b1;
          sar    <= '0;
          cnt    <= '0;
        end
        S_ACQ: if (cnt == CW'(ACQ_CYC - 1)) begin
          st              <= S_TRIAL;
          cnt             <= '0;
          idx             <= IW'(RES_W - 1);
          sar[RES_W-1]    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_TRIAL: if (cnt == CW'(TRIAL_CYC - 1)) begin
          sar[idx] <= cmp_in;
          cnt      <= '0;
          if (idx == '0) begin
            st     <= S_IDLE;
            busy_q <= 1'b0;
            valid  <= 1'b1;
          end else begin
            idx          <= idx - 1'b1;
            sar[idx - 1] <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mux_sel     = chan_addr;
  assign dac_code    = sar;
  assign busy        = busy_q;
  assign conv_clk_en = (st != S_IDLE);
  assign bus_en      = valid && rc_n && !busy_q;
  assign data_bus    = !bus_en ? {BUS_W{1'bz}} :
                       byte_sel ? {{(BUS_W-LO_W){1'b0}}, sar[LO_W-1:0]} :
                                  sar[RES_W-1 -: BUS_W];
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int RES_W     = 12,
  parameter int BUS_W     = 8,
  parameter int ACQ_CYC   = 380,
  parameter int TRIAL_CYC = 135
) (
  input logic             clk,
  input logic             rst,
  input logic             rc_n,
  input logic             byte_sel,
  input logic [RES_W-1:0] dac_code,
  input logic             busy,
  input logic             conv_clk_en,
  input logic             bus_en,
  input logic [BUS_W-1:0] data_bus
);
  localparam int RUN_LEN = ACQ_CYC + RES_W * TRIAL_CYC;
  localparam int LO_W    = RES_W - BUS_W;

  int unsigned run_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= 0;
    else              run_cnt <= run_cnt + 1;
  end

  AST_RC_LOW_HIZ:    assert property (@(posedge clk) disable iff (rst) !rc_n |-> !bus_en);                      // R1
  AST_START_CLEAR:   assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> dac_code == '0);           // R2
  AST_RUN_BOUND:     assert property (@(posedge clk) disable iff (rst) busy |-> run_cnt < RUN_LEN);               // R3
  AST_RUN_EXACT:     assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> $past(run_cnt) == RUN_LEN - 1); // R4
  AST_CLK_GATE:      assert property (@(posedge clk) disable iff (rst) busy == conv_clk_en);                      // R4
  AST_BUSY_HIZ:      assert property (@(posedge clk) disable iff (rst) busy |-> !bus_en);                         // R5
  AST_READ_AT_END:   assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> bus_en == rc_n);           // R5
  AST_NIBBLE_ZERO:   assert property (@(posedge clk) disable iff (rst) (bus_en && byte_sel) |-> data_bus[BUS_W-1:LO_W] == '0); // R7
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .RES_W(RES_W), .BUS_W(BUS_W), .ACQ_CYC(ACQ_CYC), .TRIAL_CYC(TRIAL_CYC)
) u_chk (
  .clk(clk), .rst(rst), .rc_n(rc_n), .byte_sel(byte_sel), .dac_code(dac_code),
  .busy(busy), .conv_clk_en(conv_clk_en), .bus_en(bus_en), .data_bus(data_bus)
);

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;
  localparam int ACQ = 6;
  localparam int TRL = 3;
  localparam int LEN = ACQ + 12 * TRL;

  logic clk = 0, rst = 1, rc_n = 1, byte_sel = 0, cmp_in;
  logic [2:0]  chan_addr = 0, mux_sel;
  logic [11:0] dac_code, analog = 0;
  logic        busy, conv_clk_en, bus_en;
  logic [7:0]  data_bus;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sar_conv_ctrl #(.ACQ_CYC(ACQ), .TRIAL_CYC(TRL)) u_dut (
    .clk(clk), .rst(rst), .rc_n(rc_n), .byte_sel(byte_sel), .chan_addr(chan_addr),
    .cmp_in(cmp_in), .mux_sel(mux_sel), .dac_code(dac_code), .busy(busy),
    .conv_clk_en(conv_clk_en), .bus_en(bus_en), .data_bus(data_bus));

  assign cmp_in = (analog >= dac_code);

  function automatic logic [7:0] exp_hi(input logic [11:0] c); return c[11:4]; endfunction
  function automatic logic [7:0] exp_lo(input logic [11:0] c); return {4'h0, c[3:0]}; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // mode 0: plain; 1: extra strobe pulses while busy; 2: hold rc_n low past the end
  task automatic convert(input logic [11:0] code, input int mode);
    int n;
    analog = code;
    @(negedge clk); rc_n = 0;
    @(negedge clk);
    chk("R1 busy after start", busy, 1);
    chk("R1 hiz while rc_n low", bus_en, 0);
    n = 1;
    if (mode != 2) rc_n = 1;
    while (busy) begin
      if (n == ACQ - 1) chk("R2 cleared during acquisition", dac_code, 0);
      chk("R4 clock enable while busy", conv_clk_en, 1);
      if (mode == 1 && (n % 7) == 3) rc_n = 0;
      if (mode == 1 && (n % 7) == 4) rc_n = 1;
      if (mode != 2 && rc_n) chk("R5 hiz while busy", bus_en, 0);
      chan_addr = 3'($urandom);
      #0.1 chk("R8 mux passthrough", mux_sel, chan_addr);
      @(negedge clk);
      if (busy) n++;
    end
    chk(mode == 1 ? "R3 strobes ignored, run length" : "R4 run length", n, LEN);
    chk("R4 clock enable off", conv_clk_en, 0);
    if (mode == 2) begin
      repeat (3) begin
        @(negedge clk);
        chk("R3 no restart while held low", busy, 0);
        chk("R1 hiz while rc_n low", bus_en, 0);
      end
    end
    rc_n = 1;
    byte_sel = 0;
    #0.1;
    chk("R5 bus enabled after read", bus_en, 1);
    chk("R6 R7 high byte", data_bus, exp_hi(code));
    byte_sel = 1;
    #0.1 chk("R6 R7 low nibble", data_bus, exp_lo(code));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset clock enable", conv_clk_en, 0);
    chk("R9 reset bus", bus_en, 0);
    chk("R9 reset register", dac_code, 0);
    rst = 0;
    @(negedge clk);
    chk("R5 no result yet", bus_en, 0);
    convert(12'h000, 0);
    convert(12'hFFF, 0);
    convert(12'h800, 1);
    convert(12'h7FF, 2);
    convert(12'h001, 0);
    convert(12'hFFE, 0);
    convert(12'h555, 1);
    convert(12'hAAA, 0);
    for (int i = 0; i < 60; i++) convert(12'($urandom), int'($urandom % 3));
    rst = 1;
    @(negedge clk);
    chk("R9 reset after results", bus_en, 0);
    chk("R9 reset register cleared", dac_code, 0);
    finish_run();
  end
endmodule